// File: doc/BRIEF.md
# Graphics Command Port Front End

This block is the command intake of a graphics unit. It takes 32-bit words from two write channels. The drawing channel carries draw, copy and environment commands. The control channel carries reset, abort, interrupt-acknowledge and query commands. For each word that starts a drawing command, the block works out the command class and the number of parameter words from that first word alone. It collects all of the parameters, then offers the whole command to the execution units on a valid/ready handshake.

Environment-setting commands are not dispatched. They update local registers that feed the rasteriser directly: the drawing-area corners, the drawing offset, the mode word, the texture-window word and the mask bits. After a CPU-to-VRAM copy has been dispatched, the block forwards the following data words unchanged to the transfer engine on a second valid/ready channel. It counts those words from the copy size, so it knows when the next command begins.

The block also produces a status word and a read-data register. The read-data register is loaded either with words fetched by the transfer engine or with a fixed version value on request. Back-pressure rules:
- The drawing channel is stalled while a finished command waits for `cmd_ready`.
- During the data phase of a transfer, the drawing channel follows `xfer_ready` combinationally.
- The drawing channel is also stalled in any cycle in which the control channel carries a reset or abort.
- The control channel is never stalled.

Top module: `gcp_front`

## Requirements
- R1: A drawing-channel word accepted while idle, whose bits 31:29 hold 1 to 6, is dispatched. `cmd_word` equals that first word. Classes: 1 polygon, 2 line, 3 rectangle, 4 VRAM-to-VRAM copy, 5 CPU-to-VRAM copy, 6 VRAM-to-CPU copy.
- R2: Parameter counts per class:
  - Polygon: V·(1+T+S)−S, with bit 27 selecting V=4 (else V=3), bit 26 giving T and bit 28 giving S.
  - Line: 2+S. Bit 27 has no effect on the count.
  - Rectangle: 1+T, plus 1 more when bits 28:27 are 00.
  - VRAM-to-VRAM copy: 3. CPU-to-VRAM and VRAM-to-CPU copies: 2.
  - `cmd_nparam` reports the count, and parameter k appears at `cmd_params[32k+31:32k]`.
- R3: When bits 31:29 are 0 or 7, the full byte 31:24 decides:
  - 0x01 (cache flush, 0 parameters) and 0x02 (fill, 2 parameters) are dispatched.
  - 0x00, 0x1F, 0xE1 to 0xE6 and every other byte are taken in one cycle, with no dispatch and no parameters.
- R4: `cmd_valid` rises in the cycle after the last parameter is accepted, or after the first word when there are no parameters. The command fields stay stable, and `draw_ready` stays low, until `cmd_ready` is seen.
- R5: After a CPU-to-VRAM copy is accepted by the execution units, the next ceil(W·H/2) drawing words go to `xfer_data`, with `draw_ready` equal to `xfer_ready`.
  - W is parameter 1 bits 9:0, where 0 means 1024.
  - H is parameter 1 bits 24:16, where 0 means 512.
  - The word after the last one is decoded as a new command.
- R6: Environment commands:
  - 0xE3 and 0xE4 set the top-left and bottom-right drawing-area corners, with X in bits 9:0 and Y in bits 18:10.
  - 0xE5 sets the offset, with signed X in bits 10:0 and signed Y in bits 21:11.
  - 0xE1 and 0xE2 store bits 23:0. 0xE6 stores bits 1:0.
  - After reset, the area is (0,0) to (1023,511), the offset is 0 and the other fields are 0.
- R7: Control opcode 0x01 (bits 31:24) discards any partly received command, any pending dispatch and any transfer data phase, and returns to idle. The environment registers are kept.
- R8: Control opcode 0x00 does everything 0x01 does. It also restores the environment reset values and clears the interrupt flag.
- R9: Status bits:
  - Bit 26 is 1 when idle.
  - Bit 28 is 1 when idle or in a transfer data phase.
  - Bit 27 follows `xfer_rd_pending`.
  - Bit 24 is the interrupt flag. Drawing byte 0x1F sets it; control opcodes 0x02 and 0x00 clear it.
  - All other bits are 0.
- R10: Control opcode 0x10 with bits 3:0 equal to 7 loads `rd_data` with VERSION (2). Other query indices leave `rd_data` unchanged. `xfer_rd_load` loads `rd_data` from `xfer_rd_word`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| draw_valid | input | 1 | Drawing-channel word valid |
| draw_data | input | 32 | Drawing-channel word |
| draw_ready | output | 1 | Drawing-channel word accepted this cycle when valid |
| ctrl_valid | input | 1 | Control-channel word strobe |
| ctrl_data | input | 32 | Control-channel word |
| cmd_valid | output | 1 | Complete command offered |
| cmd_ready | input | 1 | Execution units take the command |
| cmd_word | output | 32 | First word of the command |
| cmd_nparam | output | 4 | Number of parameter words |
| cmd_params | output | 352 | Parameter words, parameter 0 in the low bits |
| xfer_valid | output | 1 | Transfer data word valid |
| xfer_ready | input | 1 | Transfer engine takes the data word |
| xfer_data | output | 32 | Transfer data word |
| xfer_rd_load | input | 1 | Load read-data register from the transfer engine |
| xfer_rd_word | input | 32 | Word fetched by the transfer engine |
| xfer_rd_pending | input | 1 | Fetched VRAM data waiting to be read |
| status | output | 32 | Status word |
| rd_data | output | 32 | Read-data register |
| area_x0 | output | 10 | Drawing area left |
| area_y0 | output | 9 | Drawing area top |
| area_x1 | output | 10 | Drawing area right |
| area_y1 | output | 9 | Drawing area bottom |
| off_x | output | 11 | Signed drawing offset X |
| off_y | output | 11 | Signed drawing offset Y |
| mode_word | output | 24 | Texture-page and draw-mode settings |
| twin_word | output | 24 | Texture-window settings |
| mask_bits | output | 2 | Mask-bit settings |

## Verification
The decoder is exercised with opcodes chosen so that each flag bit changes the parameter count on its own:
- polygons with and without the quad, texture and shading bits;
- lines with and without the shading and polyline bits;
- every rectangle size code;
- all three copy classes.

Class-0/7 bytes that share their top three bits with dispatched ones tell the two-level decode apart from a three-bit decode. Transfers of 1, 5 and 512 words check the zero-means-maximum size rule and the exact point where decoding resumes. Aborts are issued mid-parameter, mid-transfer and during a pending dispatch, and each is followed by a command whose dispatch shows that nothing stale survived.

// File: rtl/gcp_pkg.sv
package gcp_pkg;
  localparam int WORD_W = 32;

  typedef enum logic [1:0] {SQ_IDLE, SQ_PARAM, SQ_ISSUE, SQ_DATA} seq_state_t;

  localparam logic [2:0] CLS_POLY = 3'd1;
  localparam logic [2:0] CLS_LINE = 3'd2;
  localparam logic [2:0] CLS_RECT = 3'd3;
  localparam logic [2:0] CLS_V2V  = 3'd4;
  localparam logic [2:0] CLS_C2V  = 3'd5;
  localparam logic [2:0] CLS_V2C  = 3'd6;

  localparam logic [7:0] OP_FLUSH = 8'h01;
  localparam logic [7:0] OP_FILL  = 8'h02;
  localparam logic [7:0] OP_IRQ   = 8'h1F;

  localparam logic [7:0] CT_RESET = 8'h00;
  localparam logic [7:0] CT_ABORT = 8'h01;
  localparam logic [7:0] CT_ACK   = 8'h02;
  localparam logic [7:0] CT_QUERY = 8'h10;
endpackage

// File: rtl/gcp_decode.sv
module gcp_decode
  import gcp_pkg::*;
#(
  parameter int PCW = 4
) (
  input  logic [WORD_W-1:0] word,
  output logic              disp,
  output logic              irq,
  output logic [2:0]        env_sel,
  output logic [PCW-1:0]    nparam
);
  int n_c;
  logic unused_low;
  assign unused_low = ^word[23:0];

  always_comb begin
    n_c     = 0;
    disp    = 1'b0;
    irq     = 1'b0;
    env_sel = 3'd0;
    case (word[31:29])
      CLS_POLY: begin
        n_c  = (word[27] ? 4 : 3) * (1 + int'(word[26]) + int'(word[28])) - int'(word[28]);
        disp = 1'b1;
      end
      CLS_LINE: begin
        n_c  = 2 + int'(word[28]);
        disp = 1'b1;
      end
      CLS_RECT: begin
        n_c  = 1 + int'(word[26]) + ((word[28:27] == 2'b00) ? 1 : 0);
        disp = 1'b1;
      end
      CLS_V2V: begin
        n_c  = 3;
        disp = 1'b1;
      end
      CLS_C2V, CLS_V2C: begin
        n_c  = 2;
        disp = 1'b1;
      end
      default: begin
        case (word[31:24])
          OP_FLUSH: disp = 1'b1;
          OP_FILL: begin
            n_c  = 2;
            disp = 1'b1;
          end
          OP_IRQ: irq = 1'b1;
          8'hE1, 8'hE2, 8'hE3, 8'hE4, 8'hE5, 8'hE6: env_sel = word[26:24];
          default: ;
        endcase
      end
    endcase
    nparam = PCW'(n_c);
  end
endmodule

// File: rtl/gcp_env.sv
module gcp_env #(
  parameter int XW = 10,
  parameter int YW = 9,
  parameter int OW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          we,
  input  logic [2:0]    sel,
  input  logic [23:0]   data,
  output logic [XW-1:0] area_x0,
  output logic [YW-1:0] area_y0,
  output logic [XW-1:0] area_x1,
  output logic [YW-1:0] area_y1,
  output logic [OW-1:0] off_x,
  output logic [OW-1:0] off_y,
  output logic [23:0]   mode_word,
  output logic [23:0]   twin_word,
  output logic [1:0]    mask_bits
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      area_x0 <= '0;
      area_y0 <= '0;
      area_x1 <= '1;
      area_y1 <= '1;
      off_x <= '0;
      off_y <= '0;
      mode_word <= '0;
      twin_word <= '0;
      mask_bits <= '0;
    end else if (clr) begin
      area_x0 <= '0;
      area_y0 <= '0;
      area_x1 <= '1;
      area_y1 <= '1;
      off_x <= '0;
      off_y <= '0;
      mode_word <= '0;
      twin_word <= '0;
      mask_bits <= '0;
    end else if (we) begin
      case (sel)
        3'd1: mode_word <= data;
        3'd2: twin_word <= data;
        3'd3: begin
          area_x0 <= data[XW-1:0];
          area_y0 <= data[XW+YW-1:XW];
        end
        3'd4: begin
          area_x1 <= data[XW-1:0];
          area_y1 <= data[XW+YW-1:XW];
        end
        3'd5: begin
          off_x <= data[OW-1:0];
          off_y <= data[2*OW-1:OW];
        end
        3'd6: mask_bits <= data[1:0];
        default: ;
      endcase
    end
  end

  AST_AREA_TL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !clr && sel == 3'd3) |=> (area_x0 == $past(data[XW-1:0]) && area_y0 == $past(data[XW+YW-1:XW]))); // R6
  AST_ENV_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (area_x1 == '1 && area_y1 == '1 && off_x == '0 && off_y == '0)); // R8
endmodule

// File: rtl/gcp_seq.sv
module gcp_seq
  import gcp_pkg::*;
#(
  parameter int MAXP = 11,
  parameter int PCW  = 4,
  parameter int XW   = 10,
  parameter int YW   = 9
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   abort,
  input  logic                   draw_valid,
  input  logic [WORD_W-1:0]      draw_data,
  output logic                   draw_ready,
  input  logic                   dec_disp,
  input  logic [PCW-1:0]         dec_nparam,
  output logic                   cmd_take,
  output logic                   cmd_valid,
  input  logic                   cmd_ready,
  output logic [WORD_W-1:0]      cmd_word,
  output logic [PCW-1:0]         cmd_nparam,
  output logic [MAXP*WORD_W-1:0] cmd_params,
  output logic                   xfer_valid,
  input  logic                   xfer_ready,
  output logic [WORD_W-1:0]      xfer_data,
  output logic                   idle,
  output logic                   in_data
);
  localparam int CW = XW + YW;
  localparam int PW = XW + YW + 2;

  seq_state_t st;
  logic [WORD_W-1:0] hdr;
  logic [MAXP-1:0][WORD_W-1:0] params;
  logic [PCW-1:0] need, got;
  logic [CW-1:0] remain, words;
  logic [XW:0] w_sz;
  logic [YW:0] h_sz;
  logic [PW-1:0] hw_cnt;
  logic [WORD_W-1:0] p1;
  logic acc;
  logic unused_p1;

  assign p1 = params[1];
  assign unused_p1 = ^{p1[15:XW], p1[WORD_W-1:16+YW]};
  assign w_sz = (p1[XW-1:0] == '0) ? (XW+1)'(1 << XW) : {1'b0, p1[XW-1:0]};
  assign h_sz = (p1[16 +: YW] == '0) ? (YW+1)'(1 << YW) : {1'b0, p1[16 +: YW]};
  assign hw_cnt = PW'(w_sz) * PW'(h_sz);
  assign words = CW'((hw_cnt + PW'(1)) >> 1);

  assign draw_ready = !abort && (st == SQ_IDLE || st == SQ_PARAM || (st == SQ_DATA && xfer_ready));
  assign acc = draw_valid && draw_ready;
  assign cmd_take = acc && st == SQ_IDLE;
  assign cmd_valid = st == SQ_ISSUE;
  assign cmd_word = hdr;
  assign cmd_nparam = need;
  assign cmd_params = params;
  assign xfer_valid = st == SQ_DATA && draw_valid && !abort;
  assign xfer_data = draw_data;
  assign idle = st == SQ_IDLE;
  assign in_data = st == SQ_DATA;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= SQ_IDLE;
      hdr <= '0;
      params <= '0;
      need <= '0;
      got <= '0;
      remain <= '0;
    end else if (abort) begin
      st <= SQ_IDLE;
      got <= '0;
    end else begin
      case (st)
        SQ_IDLE: if (acc) begin
          hdr <= draw_data;
          params <= '0;
          need <= dec_nparam;
          got <= '0;
          if (dec_disp) st <= (dec_nparam == '0) ? SQ_ISSUE : SQ_PARAM;
        end
        SQ_PARAM: if (acc) begin
          for (int i = 0; i < MAXP; i++)
            if (i == int'(got)) params[i] <= draw_data;
          got <= got + PCW'(1);
          if (got + PCW'(1) == need) st <= SQ_ISSUE;
        end
        SQ_ISSUE: if (cmd_ready) begin
          if (hdr[31:29] == CLS_C2V) begin
            remain <= words;
            st <= SQ_DATA;
          end else begin
            st <= SQ_IDLE;
          end
        end
        SQ_DATA: if (acc) begin
          remain <= remain - CW'(1);
          if (remain == CW'(1)) st <= SQ_IDLE;
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready && !abort) |=> (cmd_valid && $stable(cmd_word) && $stable(cmd_nparam) && $stable(cmd_params))); // R4
  AST_STALL_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !draw_ready); // R4
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> idle); // R7
  AST_DATA_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
    in_data |-> remain != '0); // R5
endmodule

// File: rtl/gcp_front.sv
module gcp_front
  import gcp_pkg::*;
#(
  parameter int          MAXP    = 11,
  parameter int          XW      = 10,
  parameter int          YW      = 9,
  parameter int          OW      = 11,
  parameter logic [31:0] VERSION = 32'd2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 draw_valid,
  input  logic [31:0]          draw_data,
  output logic                 draw_ready,
  input  logic                 ctrl_valid,
  input  logic [31:0]          ctrl_data,
  output logic                 cmd_valid,
  input  logic                 cmd_ready,
  output logic [31:0]          cmd_word,
  output logic [$clog2(MAXP+1)-1:0] cmd_nparam,
  output logic [MAXP*32-1:0]   cmd_params,
  output logic                 xfer_valid,
  input  logic                 xfer_ready,
  output logic [31:0]          xfer_data,
  input  logic                 xfer_rd_load,
  input  logic [31:0]          xfer_rd_word,
  input  logic                 xfer_rd_pending,
  output logic [31:0]          status,
  output logic [31:0]          rd_data,
  output logic [XW-1:0]        area_x0,
  output logic [YW-1:0]        area_y0,
  output logic [XW-1:0]        area_x1,
  output logic [YW-1:0]        area_y1,
  output logic [OW-1:0]        off_x,
  output logic [OW-1:0]        off_y,
  output logic [23:0]          mode_word,
  output logic [23:0]          twin_word,
  output logic [1:0]           mask_bits
);
  localparam int PCW = $clog2(MAXP + 1);

  logic [7:0] ctrl_op;
  logic abort, full_rst, ack, query_ver;
  logic dec_disp, dec_irq;
  logic [2:0] dec_env;
  logic [PCW-1:0] dec_nparam;
  logic cmd_take, idle, in_data;
  logic irq_q;
  logic [31:0] rd_q;
  logic unused_ctrl;

  assign ctrl_op   = ctrl_data[31:24];
  assign unused_ctrl = ^ctrl_data[23:4];
  assign full_rst  = ctrl_valid && ctrl_op == CT_RESET;
  assign abort     = full_rst || (ctrl_valid && ctrl_op == CT_ABORT);
  assign ack       = ctrl_valid && ctrl_op == CT_ACK;
  assign query_ver = ctrl_valid && ctrl_op == CT_QUERY && ctrl_data[3:0] == 4'd7;

  gcp_decode #(.PCW(PCW)) u_dec (
    .word(draw_data), .disp(dec_disp), .irq(dec_irq), .env_sel(dec_env), .nparam(dec_nparam)
  );

  gcp_seq #(.MAXP(MAXP), .PCW(PCW), .XW(XW), .YW(YW)) u_seq (
    .clk(clk), .rst_n(rst_n), .abort(abort),
    .draw_valid(draw_valid), .draw_data(draw_data), .draw_ready(draw_ready),
    .dec_disp(dec_disp), .dec_nparam(dec_nparam), .cmd_take(cmd_take),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_word(cmd_word),
    .cmd_nparam(cmd_nparam), .cmd_params(cmd_params),
    .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .xfer_data(xfer_data),
    .idle(idle), .in_data(in_data)
  );

  gcp_env #(.XW(XW), .YW(YW), .OW(OW)) u_env (
    .clk(clk), .rst_n(rst_n), .clr(full_rst),
    .we(cmd_take && dec_env != 3'd0), .sel(dec_env), .data(draw_data[23:0]),
    .area_x0(area_x0), .area_y0(area_y0), .area_x1(area_x1), .area_y1(area_y1),
    .off_x(off_x), .off_y(off_y), .mode_word(mode_word), .twin_word(twin_word),
    .mask_bits(mask_bits)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      rd_q <= '0;
    end else begin
      if (full_rst || ack) irq_q <= 1'b0;
      else if (cmd_take && dec_irq) irq_q <= 1'b1;
      if (query_ver) rd_q <= VERSION;
      else if (xfer_rd_load) rd_q <= xfer_rd_word;
    end
  end

  assign rd_data = rd_q;
  assign status = {3'b000, idle || in_data, xfer_rd_pending, idle, 1'b0, irq_q, 24'h000000};

  AST_VERSION_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    query_ver |=> rd_data == VERSION); // R10
  AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_take && dec_irq && !ctrl_valid) |=> status[24]); // R9
  AST_XFER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |-> !status[26]); // R5
  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (full_rst || ack) |=> !status[24]); // R9
endmodule

// File: tb/sim_gcp_front.sv
module sim_gcp_front;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic draw_valid = 1'b0;
  logic [31:0] draw_data = '0;
  logic draw_ready;
  logic ctrl_valid = 1'b0;
  logic [31:0] ctrl_data = '0;
  logic cmd_valid;
  logic cmd_ready = 1'b0;
  logic [31:0] cmd_word;
  logic [3:0] cmd_nparam;
  logic [351:0] cmd_params;
  logic xfer_valid;
  logic xfer_ready = 1'b1;
  logic [31:0] xfer_data;
  logic xfer_rd_load = 1'b0;
  logic [31:0] xfer_rd_word = '0;
  logic xfer_rd_pending = 1'b0;
  logic [31:0] status, rd_data;
  logic [9:0] area_x0, area_x1;
  logic [8:0] area_y0, area_y1;
  logic [10:0] off_x, off_y;
  logic [23:0] mode_word, twin_word;
  logic [1:0] mask_bits;

  int checks = 0;
  int errors = 0;
  int xcnt = 0;
  logic [31:0] last_x = '0;

  always #4 clk = ~clk;

  gcp_front u0 (
    .clk(clk), .rst_n(rst_n), .draw_valid(draw_valid), .draw_data(draw_data),
    .draw_ready(draw_ready), .ctrl_valid(ctrl_valid), .ctrl_data(ctrl_data),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_word(cmd_word),
    .cmd_nparam(cmd_nparam), .cmd_params(cmd_params), .xfer_valid(xfer_valid),
    .xfer_ready(xfer_ready), .xfer_data(xfer_data), .xfer_rd_load(xfer_rd_load),
    .xfer_rd_word(xfer_rd_word), .xfer_rd_pending(xfer_rd_pending), .status(status),
    .rd_data(rd_data), .area_x0(area_x0), .area_y0(area_y0), .area_x1(area_x1),
    .area_y1(area_y1), .off_x(off_x), .off_y(off_y), .mode_word(mode_word),
    .twin_word(twin_word), .mask_bits(mask_bits)
  );

  always @(posedge clk) begin
    if (xfer_valid && xfer_ready) begin
      xcnt <= xcnt + 1;
      last_x <= xfer_data;
    end
  end

  // {dispatched, parameter count, first word}
  localparam logic [40:0] VEC [0:17] = '{
    {1'b1, 8'd3,  32'h20000000},
    {1'b1, 8'd5,  32'h30000000},
    {1'b1, 8'd8,  32'h2C000000},
    {1'b1, 8'd11, 32'h3C000000},
    {1'b1, 8'd6,  32'h24000000},
    {1'b1, 8'd2,  32'h40000000},
    {1'b1, 8'd3,  32'h50000000},
    {1'b1, 8'd2,  32'h48000000},
    {1'b1, 8'd2,  32'h60000000},
    {1'b1, 8'd1,  32'h68004080},
    {1'b1, 8'd2,  32'h7C000000},
    {1'b1, 8'd3,  32'h80000000},
    {1'b1, 8'd2,  32'hC0000000},
    {1'b1, 8'd2,  32'h02000000},
    {1'b1, 8'd0,  32'h01000000},
    {1'b0, 8'd0,  32'h00000000},
    {1'b0, 8'd0,  32'h03000000},
    {1'b0, 8'd0,  32'hE7000000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] w);
    @(negedge clk);
    draw_valid = 1'b1;
    draw_data = w;
    while (!draw_ready) @(negedge clk);
    @(negedge clk);
    draw_valid = 1'b0;
  endtask

  task automatic ctrl(input logic [31:0] w);
    @(negedge clk);
    ctrl_valid = 1'b1;
    ctrl_data = w;
    @(negedge clk);
    ctrl_valid = 1'b0;
  endtask

  task automatic take_cmd();
    @(negedge clk);
    cmd_ready = 1'b1;
    @(negedge clk);
    cmd_ready = 1'b0;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    check("R9 reset status", status, 32'h14000000);
    check("R6 reset area br", {area_x1, area_y1}, {10'd1023, 9'd511});
    check("R6 reset area tl/offset", {area_x0, area_y0, off_x, off_y}, '0);
    check("R4 reset no cmd", {31'd0, cmd_valid}, 32'd0);
    check("R10 reset rd_data", rd_data, 32'd0);

    // table walk over opcode decode
    for (int i = 0; i < 18; i++) begin
      logic [31:0] w;
      int n;
      logic d;
      w = VEC[i][31:0];
      n = int'(VEC[i][39:32]);
      d = VEC[i][40];
      send(w);
      for (int k = 0; k < n; k++) send(32'hA5000000 | (i << 8) | k);
      if (d) begin
        check(w[31:29] inside {3'd0, 3'd7} ? "R3 dispatch" : "R1 dispatch", {31'd0, cmd_valid}, 32'd1);
        check("R1 cmd_word", cmd_word, w);
        check("R2 nparam", {28'd0, cmd_nparam}, n);
        if (n > 0) check("R2 last param", cmd_params[(n-1)*32 +: 32], 32'hA5000000 | (i << 8) | (n - 1));
        take_cmd();
        check("R4 idle after take", {31'd0, status[26]}, 32'd1);
      end else begin
        check("R3 no dispatch", {31'd0, cmd_valid}, 32'd0);
        check("R3 still idle", {31'd0, status[26]}, 32'd1);
      end
    end

    // R4: hold under back-pressure
    send(32'h68FFFFFF);
    send(32'h00050006);
    draw_valid = 1'b1;
    draw_data = 32'h01000000;
    repeat (3) @(negedge clk);
    check("R4 valid held", {31'd0, cmd_valid}, 32'd1);
    check("R4 word held", cmd_word, 32'h68FFFFFF);
    check("R4 draw stalled", {31'd0, draw_ready}, 32'd0);
    draw_valid = 1'b0;
    take_cmd();

    // R5: CPU-to-VRAM, 2x1 -> 1 word
    send(32'hA0000000);
    send(32'h01FF0000);
    send(32'h00010002);
    check("R1 copy dispatch", cmd_word, 32'hA0000000);
    take_cmd();
    check("R9 data phase status", status & 32'h14000000, 32'h10000000);
    xcnt = 0;
    send(32'hFFFFFFFF);
    check("R5 one word passed", xcnt, 1);
    check("R5 data value", last_x, 32'hFFFFFFFF);
    check("R5 idle after data", {31'd0, status[26]}, 32'd1);
    send(32'h01000000);
    check("R5 next word is command", {31'd0, cmd_valid}, 32'd1);
    take_cmd();

    // R5: 3x3 -> 5 words with back-pressure
    send(32'hA0000000);
    send(32'h0);
    send(32'h00030003);
    take_cmd();
    xcnt = 0;
    @(negedge clk);
    xfer_ready = 1'b0;
    draw_valid = 1'b1;
    draw_data = 32'h12345678;
    @(negedge clk);
    check("R5 stall follows xfer_ready", {31'd0, draw_ready}, 32'd0);
    check("R5 xfer_valid offered", {31'd0, xfer_valid}, 32'd1);
    draw_valid = 1'b0;
    xfer_ready = 1'b1;
    for (int k = 0; k < 4; k++) send(32'h100 + k);
    check("R5 4 of 5 still data", {31'd0, status[26]}, 32'd0);
    send(32'h200);
    check("R5 5 words", xcnt, 5);
    check("R5 idle after 5", {31'd0, status[26]}, 32'd1);

    // R5: width 0 means 1024 -> 512 words
    send(32'hA0000000);
    send(32'h0);
    send(32'h00010000);
    take_cmd();
    xcnt = 0;
    for (int k = 0; k < 511; k++) send(k);
    check("R5 511 still data", {31'd0, status[26]}, 32'd0);
    send(32'h1FF);
    check("R5 512 words", xcnt, 512);
    check("R5 idle after 512", {31'd0, status[26]}, 32'd1);

    // R6: environment registers
    send(32'hE300C864);
    check("R6 area tl", {22'd0, area_x0}, 32'd100);
    check("R6 area tl y", {23'd0, area_y0}, 32'd50);
    send(32'hE403BD3F);
    check("R6 area br", {3'd0, area_x1, 10'd0, area_y1}, {3'd0, 10'd319, 10'd0, 9'd239});
    send(32'hE5003FFD);
    check("R6 offset", {5'd0, off_x, 5'd0, off_y}, {5'd0, 11'h7FD, 5'd0, 11'd7});
    send(32'hE1000400);
    check("R6 mode", {8'd0, mode_word}, 32'h400);
    send(32'hE2012345);
    check("R6 twin", {8'd0, twin_word}, 32'h012345);
    send(32'hE6000003);
    check("R6 mask", {30'd0, mask_bits}, 32'd3);
    check("R6 no dispatch", {31'd0, cmd_valid}, 32'd0);

    // R7: abort mid-parameter keeps env
    send(32'h20000000);
    send(32'h11111111);
    ctrl(32'h01000000);
    check("R7 idle after abort", {31'd0, status[26]}, 32'd1);
    check("R7 env kept", {22'd0, area_x0}, 32'd100);
    send(32'h01000000);
    check("R7 fresh cmd word", cmd_word, 32'h01000000);
    check("R7 fresh nparam", {28'd0, cmd_nparam}, 32'd0);
    // abort pending dispatch
    ctrl(32'h01000000);
    check("R7 pending dropped", {31'd0, cmd_valid}, 32'd0);
    // abort transfer data phase
    send(32'hA0000000);
    send(32'h0);
    send(32'h00040004);
    take_cmd();
    send(32'h1);
    ctrl(32'h01000000);
    check("R7 transfer abandoned", {31'd0, status[26]}, 32'd1);
    xcnt = 0;
    send(32'h00000000);
    check("R7 word decoded not passed", xcnt, 0);
    check("R7 nop not dispatched", {31'd0, cmd_valid}, 32'd0);

    // R9: interrupt flag
    send(32'h1F000000);
    check("R9 irq set", {31'd0, status[24]}, 32'd1);
    ctrl(32'h02000000);
    check("R9 irq ack", {31'd0, status[24]}, 32'd0);
    send(32'h1F000000);
    xfer_rd_pending = 1'b1;
    @(negedge clk);
    check("R9 status bits", status, 32'h1D000000);
    xfer_rd_pending = 1'b0;

    // R8: full reset
    ctrl(32'h00000000);
    check("R8 irq cleared", {31'd0, status[24]}, 32'd0);
    check("R8 area restored", {area_x0, area_y0, area_x1, area_y1}, {10'd0, 9'd0, 10'd1023, 9'd511});
    check("R8 offset/mode restored", {off_x, off_y, mask_bits}, '0);
    check("R8 mode restored", {8'd0, mode_word}, 32'd0);

    // R10: read-data register
    @(negedge clk);
    xfer_rd_load = 1'b1;
    xfer_rd_word = 32'hFFFFFFFF;
    @(negedge clk);
    xfer_rd_load = 1'b0;
    check("R10 load from transfer", rd_data, 32'hFFFFFFFF);
    ctrl(32'h10000004);
    check("R10 other index unchanged", rd_data, 32'hFFFFFFFF);
    ctrl(32'h10000007);
    check("R10 version", rd_data, 32'd2);

    finish_run();
  end
endmodule